// File: doc/BRIEF.md
# Selectable Half-Band Interpolation Chain

This block raises the sample rate of a transmit stream before it reaches a DAC. Signed 12-bit words arrive on a single fast clock, each marked by an input strobe. The block returns them at one, two or four times the input word rate as a stream of valid-flagged output words. Two half-band 2x stages are cascaded. The first is long, with 11 symmetric coefficient pairs plus a centre tap, and it runs at the input rate. The second is short, with 3 pairs plus a centre tap, and it runs at the doubled rate. The 2x setting uses only the first stage. The 4x setting feeds the first stage's output into the second. Bypass passes words through unfiltered.

Each stage has unity passband gain. Its centre phase reproduces the delayed input exactly. Its other phase is a symmetric constant-coefficient sum, which is rounded and saturated back to 12 bits. The latency from the first input word to the first output word is fixed for each setting, so a downstream controller can count it. Changing the rate setting empties every delay line, and the new setting then refills from a zero history.

Top module: `hbi_interp`

## Requirements
- R1: `rate_sel` encodes the setting: 00 selects 4x, 01 selects 2x, 10 selects bypass. The source pulses `in_ce` once every 4, 2 and 1 clocks respectively, so that a valid output word can appear on every clock.
- R2: In bypass, the word taken with `in_ce` in cycle t appears on `out_data` with `out_valid` high in cycle t+2, unfiltered.
- R3: In 2x, the outputs alternate. Each even output equals input x[m]. The odd output that follows it is Q(sum over k=0..10 of c1[k]*(x[m-k]+x[m+1+k])), with c1 = 20763, -6669, 3709, -2348, 1546, -1014, 639, -376, 195, -79, 18. Inputs from before the last flush count as zero.
- R4: In 4x, the 2x sequence of R3 is interpolated again in the same way, with c2 = 19200, -3200, 384 (k=0..2).
- R5: Q(a) = floor((a + 16384) / 32768), clipped to the range -2048..2047.
- R6: After reset or a flush, the first `out_valid` comes 25 clocks after the first strobe in 2x, 55 clocks after it in 4x, and 2 clocks after it in bypass.
- R7: While `rate_sel` is 11 (reserved), `out_valid` stays low.
- R8: A change of `rate_sel` forces `out_valid` low in the next cycle and clears all filter history. A strobe in the cycle of the change is dropped.
- R9: `out_data` changes only in cycles where `out_valid` is high.
- R10: During and after reset, before any input arrives, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_sel | input | 2 | Rate setting (00 4x, 01 2x, 10 bypass, 11 reserved) |
| in_ce | input | 1 | Input word strobe |
| in_data | input | 12 | Signed input word |
| out_data | output | 12 | Signed output word |
| out_valid | output | 1 | Output word valid |

## Verification
A pseudo-random stream is compared word by word against a reference cascade in bypass, 2x and 4x. A mismatch there points to a wrong phase order or a wrong stage feed. A single impulse isolates each coefficient of the long stage. A full-scale negative-to-positive step drives both odd-phase sums past the 12-bit range, which separates correct rounding and clipping from wraparound. A switch made mid-stream from 2x to 4x, followed by a fresh 4x stream, shows whether old history leaks through the flush. A run in the reserved setting shows that the block stays silent there.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  typedef enum logic [1:0] {
    RATE_X4  = 2'b00,
    RATE_X2  = 2'b01,
    RATE_X1  = 2'b10,
    RATE_RSV = 2'b11
  } rate_e;

  // Odd-phase pair weights, Q15, each set sums to 16384 (unity gain).
  function automatic int hb_coef(input int stg, input int k);
    int c;
    c = 0;
    if (stg == 0) begin
      case (k)
        0: c = 20763;
        1: c = -6669;
        2: c = 3709;
        3: c = -2348;
        4: c = 1546;
        5: c = -1014;
        6: c = 639;
        7: c = -376;
        8: c = 195;
        9: c = -79;
        10: c = 18;
        default: c = 0;
      endcase
    end else begin
      case (k)
        0: c = 19200;
        1: c = -3200;
        2: c = 384;
        default: c = 0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/hbi_rndsat.sv
module hbi_rndsat #(
  parameter int IW   = 34,
  parameter int DW   = 12,
  parameter int FRAC = 15
) (
  input  logic signed [IW-1:0] acc_i,
  output logic signed [DW-1:0] q_o
);
  localparam int QW   = IW - FRAC + 1;
  localparam int MAXI = 2**(DW-1) - 1;
  localparam logic signed [IW:0] HALF = {{(IW-FRAC+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [QW-1:0] QMAX = QW'(MAXI);
  localparam logic signed [QW-1:0] QMIN = QW'(-MAXI - 1);

  logic signed [IW:0]   rnd;
  logic signed [QW-1:0] q;

  always_comb begin
    rnd = {acc_i[IW-1], acc_i} + HALF;
    q   = rnd[IW:FRAC];
    if (q > QMAX)      q_o = {1'b0, {(DW-1){1'b1}}};
    else if (q < QMIN) q_o = {1'b1, {(DW-1){1'b0}}};
    else               q_o = q[DW-1:0];
  end
endmodule

// File: rtl/hbi_stage.sv
module hbi_stage
  import hbi_pkg::*;
#(
  parameter int DW   = 12,
  parameter int K    = 11,
  parameter int STG  = 0,
  parameter int CW   = 16,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 s_ce,
  input  logic                 p_ce,
  input  logic signed [DW-1:0] s_din,
  output logic signed [DW-1:0] y,
  output logic                 y_vld
);
  localparam int TAPS = 2 * K;
  localparam int AW   = DW + 1 + CW + $clog2(K) + 1;
  localparam int CNTW = $clog2(K + 2);
  localparam logic [CNTW-1:0] FULL = CNTW'(K + 1);

  logic signed [DW-1:0] dly_q [TAPS];
  logic signed [DW-1:0] dly_n [TAPS];
  logic [CNTW-1:0]      cnt_q, cnt_n;
  logic                 ld_q, ld_n;
  logic signed [DW-1:0] y_q, y_n;
  logic                 v_q, v_n;

  logic signed [DW:0]   pair [K];
  logic signed [AW-1:0] prod [K];
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] odd_s;

  generate
    for (genvar g = 0; g < K; g++) begin : g_tap
      localparam logic signed [CW-1:0] COEF = CW'(hb_coef(STG, g));
      assign pair[g] = (DW+1)'(dly_q[K-1-g]) + (DW+1)'(dly_q[K+g]);
      assign prod[g] = AW'(pair[g]) * AW'(COEF);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int k = 0; k < K; k++) acc = acc + prod[k];
  end

  hbi_rndsat #(.IW(AW), .DW(DW), .FRAC(FRAC)) u_rndsat (
    .acc_i (acc),
    .q_o   (odd_s)
  );

  always_comb begin
    dly_n = dly_q;
    cnt_n = cnt_q;
    ld_n  = 1'b0;
    y_n   = y_q;
    v_n   = 1'b0;
    if (flush) begin
      for (int i = 0; i < TAPS; i++) dly_n[i] = '0;
      cnt_n = '0;
      y_n   = '0;
    end else begin
      if (s_ce) begin
        dly_n[0] = s_din;
        for (int i = 1; i < TAPS; i++) dly_n[i] = dly_q[i-1];
        if (cnt_q != FULL) cnt_n = cnt_q + 1'b1;
        ld_n = 1'b1;
      end
      if (ld_q && (cnt_q == FULL)) begin
        y_n = dly_q[K];
        v_n = 1'b1;
      end else if (p_ce && (cnt_q == FULL)) begin
        y_n = odd_s;
        v_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) dly_q[i] <= '0;
      cnt_q <= '0;
      ld_q  <= 1'b0;
      y_q   <= '0;
      v_q   <= 1'b0;
    end else begin
      dly_q <= dly_n;
      cnt_q <= cnt_n;
      ld_q  <= ld_n;
      y_q   <= y_n;
      v_q   <= v_n;
    end
  end

  assign y     = y_q;
  assign y_vld = v_q;
endmodule

// File: rtl/hbi_interp.sv
module hbi_interp
  import hbi_pkg::*;
#(
  parameter int DW   = 12,
  parameter int K1   = 11,
  parameter int K2   = 3,
  parameter int CW   = 16,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           rate_sel,
  input  logic                 in_ce,
  input  logic signed [DW-1:0] in_data,
  output logic signed [DW-1:0] out_data,
  output logic                 out_valid
);
  rate_e mode_q;
  logic  flush;

  logic [2:0] ce_q, ce_n;
  logic [1:0] s2ce_q, s2ce_n;
  logic       s1_sce, s1_pce, s2_sce, s2_pce;

  logic signed [DW-1:0] s1_y, s2_y;
  logic                 s1_v, s2_v;

  logic signed [DW-1:0] byp_q, byp_n;
  logic                 bv_q, bv_n;

  logic signed [DW-1:0] sel_d, od_q, od_n;
  logic                 sel_v, ov_q, ov_n;

  assign flush  = (rate_sel != mode_q);
  assign s1_sce = in_ce && !flush && ((mode_q == RATE_X2) || (mode_q == RATE_X4));
  assign s1_pce = (mode_q == RATE_X4) ? ce_q[2] : ce_q[1];
  assign s2_sce = s1_v && !flush && (mode_q == RATE_X4);
  assign s2_pce = s2ce_q[1];

  hbi_stage #(.DW(DW), .K(K1), .STG(0), .CW(CW), .FRAC(FRAC)) u_stage1 (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .s_ce  (s1_sce),
    .p_ce  (s1_pce),
    .s_din (in_data),
    .y     (s1_y),
    .y_vld (s1_v)
  );

  hbi_stage #(.DW(DW), .K(K2), .STG(1), .CW(CW), .FRAC(FRAC)) u_stage2 (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .s_ce  (s2_sce),
    .p_ce  (s2_pce),
    .s_din (s1_y),
    .y     (s2_y),
    .y_vld (s2_v)
  );

  always_comb begin
    ce_n   = flush ? '0 : {ce_q[1:0], s1_sce};
    s2ce_n = flush ? '0 : {s2ce_q[0], s2_sce};
    bv_n   = in_ce && !flush && (mode_q == RATE_X1);
    byp_n  = bv_n ? in_data : byp_q;
  end

  always_comb begin
    case (mode_q)
      RATE_X4: begin sel_d = s2_y;  sel_v = s2_v; end
      RATE_X2: begin sel_d = s1_y;  sel_v = s1_v; end
      RATE_X1: begin sel_d = byp_q; sel_v = bv_q; end
      default: begin sel_d = '0;    sel_v = 1'b0; end
    endcase
    ov_n = sel_v && !flush;
    od_n = ov_n ? sel_d : od_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RATE_X4;
      ce_q   <= '0;
      s2ce_q <= '0;
      byp_q  <= '0;
      bv_q   <= 1'b0;
      od_q   <= '0;
      ov_q   <= 1'b0;
    end else begin
      mode_q <= rate_e'(rate_sel);
      ce_q   <= ce_n;
      s2ce_q <= s2ce_n;
      byp_q  <= byp_n;
      bv_q   <= bv_n;
      od_q   <= od_n;
      ov_q   <= ov_n;
    end
  end

  assign out_data  = od_q;
  assign out_valid = ov_q;
endmodule

// File: rtl/hbi_interp_chk.sv
module hbi_interp_chk #(
  parameter int DW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           rate_sel,
  input logic                 in_ce,
  input logic signed [DW-1:0] in_data,
  input logic signed [DW-1:0] out_data,
  input logic                 out_valid
);
  // R7: reserved setting never produces output
  a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'b11 && $past(rate_sel) == 2'b11) |-> !out_valid);

  // R8: a setting change blanks the next output cycle
  a_r8_flush_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != $past(rate_sel)) |=> !out_valid);

  // R2: bypass forwards the strobed word two cycles later
  a_r2_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ce) && $past(rate_sel) == 2'b10 && $past(rate_sel, 2) == 2'b10
     && rate_sel == 2'b10)
    |=> (out_valid && out_data == $past(in_data, 2)));

  // R9: data holds whenever valid is low
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind hbi_interp hbi_interp_chk #(.DW(DW)) i_hbi_interp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rate_sel  (rate_sel),
  .in_ce     (in_ce),
  .in_data   (in_data),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/test_hbi_interp.sv
module test_hbi_interp;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic                 clk;
  logic                 rst_n;
  logic [1:0]           rate_sel;
  logic                 in_ce;
  logic signed [DW-1:0] in_data;
  logic signed [DW-1:0] out_data;
  logic                 out_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cap [0:1023];
  int cap_n = 0;
  int first_out = 0;
  int first_in  = 0;
  int hold_err  = 0;
  int last_d    = 0;
  int mi [0:1023];
  int mo [0:2047];

  hbi_interp i_hbi_interp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .in_ce     (in_ce),
    .in_data   (in_data),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (cap_n == 0) first_out = cyc;
        if (cap_n < 1024) cap[cap_n] = int'(out_data);
        cap_n++;
      end else if (int'(out_data) != last_d) begin
        hold_err++;
      end
      last_d = int'(out_data);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bcoef(input int stg, input int k);
    int c1 [11] = '{20763, -6669, 3709, -2348, 1546, -1014, 639, -376, 195, -79, 18};
    int c2 [3]  = '{19200, -3200, 384};
    return (stg == 0) ? c1[k] : c2[k];
  endfunction

  function automatic int rs(input longint a);
    longint r;
    r = (a + 64'sd16384) >>> 15;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  function automatic int pat_val(input int pat, input int i);
    bit [31:0] h;
    h = 32'(i) * 32'd2654435761 + 32'd40503;
    case (pat)
      0: return int'(h[23:12]) - 2048;
      1: return (i == 14) ? 1000 : 0;
      2: return (i < 20) ? -2048 : 2047;
      default: return -1700;
    endcase
  endfunction

  // reference half-band stage: mi[0..nin-1] -> mo[0..nout-1]
  task automatic ref_stage(input int stg, input int nin, output int nout);
    int kk;
    longint acc;
    kk = (stg == 0) ? 11 : 3;
    nout = 0;
    for (int m = 0; m + kk < nin; m++) begin
      mo[nout] = mi[m];
      nout++;
      acc = 0;
      for (int k = 0; k < kk; k++) begin
        acc += longint'(bcoef(stg, k)) *
               longint'(mi[m+1+k] + ((m - k >= 0) ? mi[m-k] : 0));
      end
      mo[nout] = rs(acc);
      nout++;
    end
  endtask

  task automatic drive(input int n, input int gap, input int pat);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_ce   = 1'b1;
      in_data = DW'(pat_val(pat, i));
      if (i == 0) first_in = cyc;
      for (int g = 1; g < gap; g++) begin
        @(posedge clk); #1;
        in_ce = 1'b0;
      end
    end
    if (gap == 1) begin
      @(posedge clk); #1;
    end
    in_ce = 1'b0;
  endtask

  // flush through the reserved code, stream n words, compare with reference
  task automatic run_mode(input logic [1:0] mode, input int n, input int pat,
                          input int lat, input string req);
    int gap, nexp, n1;
    @(posedge clk); #1;
    rate_sel = 2'b11;
    repeat (2) @(posedge clk);
    #1 rate_sel = mode;
    repeat (4) @(posedge clk);
    #1;
    cap_n = 0;
    hold_err = 0;
    gap = (mode == 2'b00) ? 4 : (mode == 2'b01) ? 2 : 1;
    drive(n, gap, pat);
    repeat (120) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < n; i++) mi[i] = pat_val(pat, i);
    if (mode == 2'b10) begin
      for (int i = 0; i < n; i++) mo[i] = mi[i];
      nexp = n;
    end else begin
      ref_stage(0, n, nexp);
      if (mode == 2'b00) begin
        n1 = nexp;
        for (int i = 0; i < n1; i++) mi[i] = mo[i];
        ref_stage(1, n1, nexp);
      end
    end
    check(req, "output count", cap_n, nexp);
    for (int i = 0; i < nexp && i < cap_n; i++) begin
      check(req, $sformatf("word %0d", i), cap[i], mo[i]);
    end
    check("R6", "latency", first_out - first_in, lat);
    check("R9", "hold while invalid", hold_err, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10", "valid after reset", int'(out_valid), 0);
    check("R10", "data after reset", int'(out_data), 0);
  endtask

  task automatic t_bypass;
    run_mode(2'b10, 30, 0, 2, "R2");
  endtask

  task automatic t_x2_impulse;
    run_mode(2'b01, 36, 1, 25, "R3");
  endtask

  task automatic t_x2_random;
    run_mode(2'b01, 40, 0, 25, "R1");
  endtask

  task automatic t_x2_step;
    int clipped;
    run_mode(2'b01, 40, 2, 25, "R5");
    clipped = 0;
    for (int i = 0; i < cap_n; i++) if (cap[i] == 2047 && i % 2 == 1) clipped++;
    check("R5", "odd words clipped high", int'(clipped > 0), 1);
  endtask

  task automatic t_x4_random;
    run_mode(2'b00, 40, 0, 55, "R4");
  endtask

  task automatic t_x4_dc;
    run_mode(2'b00, 40, 3, 55, "R4");
  endtask

  task automatic t_reserved;
    @(posedge clk); #1;
    rate_sel = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    cap_n = 0;
    drive(40, 1, 0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R7", "outputs in reserved setting", cap_n, 0);
  endtask

  task automatic t_switch;
    int seen;
    @(posedge clk); #1;
    rate_sel = 2'b01;
    repeat (4) @(posedge clk);
    #1;
    drive(20, 2, 0);
    rate_sel = 2'b00;
    @(negedge clk);
    check("R8", "valid before switch takes effect", int'(out_valid), 1);
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    check("R8", "valid after switch", seen, 0);
    // fresh 4x stream must match a zero-history reference
    cap_n = 0;
    hold_err = 0;
    drive(40, 4, 3);
    repeat (120) @(posedge clk);
    @(negedge clk);
    begin
      int n1, nexp;
      for (int i = 0; i < 40; i++) mi[i] = pat_val(3, i);
      ref_stage(0, 40, n1);
      for (int i = 0; i < n1; i++) mi[i] = mo[i];
      ref_stage(1, n1, nexp);
      check("R8", "count after flush", cap_n, nexp);
      for (int i = 0; i < nexp && i < cap_n; i++)
        check("R8", $sformatf("word %0d after flush", i), cap[i], mo[i]);
      check("R6", "latency after switch", first_out - first_in, 55);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL all: watchdog expired, actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    rate_sel = 2'b00;
    in_ce    = 1'b0;
    in_data  = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_x2_impulse();
    t_x2_random();
    t_x2_step();
    t_x4_random();
    t_x4_dc();
    t_reserved();
    t_switch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule